// File: doc/BRIEF.md
# Operand Bypass and Load Stall Controller

This block supplies the hazard control for a five-stage in-order pipeline: fetch, decode, execute, memory and write-back. Register results are committed in the write-back stage. Each instruction carries its destination register address down the pipeline registers. The block compares the two source registers of the instruction now in execute against the destinations held in the memory and write-back stages. From that comparison it produces a 2-bit select code for each ALU input mux, so that a dependent ALU instruction can follow its producer with no lost cycle.

A load has no result until the end of the memory stage, so an instruction that needs that result right after the load cannot be served by bypassing. The block spots this case by comparing the decode-stage sources with the destination of a load in execute. It then holds the PC and the fetch/decode register for one cycle and clears the control bits that enter execute, which inserts a bubble. A consumer three stages behind its producer needs nothing from the block, because the register file hands back a value written in the same cycle. The block only drives control signals. It contains no datapath muxes and does no branch handling.

The stall side is a two-state machine. In ST_FLOW the pipeline runs, and a load-use match moves it to ST_HELD (transition "stall") for exactly one cycle. ST_HELD suppresses any further stall request and always returns to ST_FLOW (transition "release"). Reset puts the machine in ST_FLOW.

Top module: `hazard_unit`

## Requirements
- R1: With no matching producer in any stage, both select codes are 2'b00 (register file), pc_wr_en and fd_wr_en are 1 and ex_bubble is 0; this is also the state right after reset.
- R2: When the memory stage writes a non-zero register equal to an execute source, that operand's select is 2'b10.
- R3: When only the write-back stage writes a non-zero register equal to an execute source, that operand's select is 2'b01.
- R4: When both the memory and write-back stages match the same source, the memory stage wins and the select is 2'b10.
- R5: A destination of register 0 never causes forwarding or a stall.
- R6: A stage whose write enable is low never causes forwarding, even when its destination matches.
- R7: If execute holds a load whose non-zero destination equals either decode source, then in that same cycle pc_wr_en and fd_wr_en are 0 and ex_bubble is 1.
- R8: A non-load instruction in execute never causes a stall, whatever its destination.
- R9: A cycle that stalls is always followed by a cycle with no stall, even if the load-use match is still present. After that cycle, stalling is possible again.
- R10: The two operand selects are worked out independently, so each can show a different code in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_src_a | input | REG_AW | First source register of the decode instruction |
| dec_src_b | input | REG_AW | Second source register of the decode instruction |
| ex_src_a | input | REG_AW | First source register of the execute instruction |
| ex_src_b | input | REG_AW | Second source register of the execute instruction |
| ex_dst | input | REG_AW | Destination register of the execute instruction |
| ex_is_load | input | 1 | Execute instruction is a load |
| mem_dst | input | REG_AW | Destination register in the memory stage |
| mem_wr_en | input | 1 | Memory-stage instruction writes a register |
| wb_dst | input | REG_AW | Destination register in the write-back stage |
| wb_wr_en | input | 1 | Write-back instruction writes a register |
| fwd_sel_a | output | 2 | ALU input A select: 00 register file, 10 memory stage, 01 write-back |
| fwd_sel_b | output | 2 | ALU input B select, same coding |
| pc_wr_en | output | 1 | PC may update |
| fd_wr_en | output | 1 | Fetch/decode register may load |
| ex_bubble | output | 1 | Clear the control bits entering execute |

## Verification
The bench focuses on the corner cases where a faulty implementation gives wrong results while looking correct most of the time. If both stages match the same register and the priority is inverted, the ALU receives stale write-back data. A design that compares register 0 or ignores write enables forwards junk or inserts stalls that are not needed. Other checks cover a stall raised by an ALU producer and a load match on the second decode source only. The bench also holds a load-use match on the inputs for several cycles. A controller that lacks the hold state would then freeze the pipeline for good, and one that never releases would never stall again.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
    typedef enum logic [1:0] {
        SEL_RF  = 2'b00,
        SEL_WB  = 2'b01,
        SEL_MEM = 2'b10
    } opnd_sel_e;

    typedef enum logic {
        ST_FLOW = 1'b0,
        ST_HELD = 1'b1
    } lu_state_e;
endpackage

// File: rtl/fwd_pick.sv
module fwd_pick
    import hzd_pkg::*;
#(
    parameter int RW = 5
) (
    input  logic [RW-1:0] src,
    input  logic [RW-1:0] mem_dst,
    input  logic          mem_wr,
    input  logic [RW-1:0] wb_dst,
    input  logic          wb_wr,
    output opnd_sel_e     sel
);
    logic mem_hit;
    logic wb_hit;

    always_comb begin
        mem_hit = mem_wr && (mem_dst != '0) && (mem_dst == src);
        wb_hit  = wb_wr  && (wb_dst  != '0) && (wb_dst  == src);
        // memory stage holds the younger value, so it is checked first
        if (mem_hit)     sel = SEL_MEM;
        else if (wb_hit) sel = SEL_WB;
        else             sel = SEL_RF;
    end
endmodule

// File: rtl/load_use_fsm.sv
module load_use_fsm
    import hzd_pkg::*;
#(
    parameter int RW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [RW-1:0] dec_src_a,
    input  logic [RW-1:0] dec_src_b,
    input  logic [RW-1:0] ex_dst,
    input  logic          ex_is_load,
    output logic          hold
);
    lu_state_e state_q, state_d;
    logic      lu_match;

    assign lu_match = ex_is_load && (ex_dst != '0) &&
                      ((ex_dst == dec_src_a) || (ex_dst == dec_src_b));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FLOW;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        hold    = 1'b0;
        unique case (state_q)
            ST_FLOW: begin
                hold = lu_match;
                if (lu_match) state_d = ST_HELD;
            end
            ST_HELD: begin
                state_d = ST_FLOW;
            end
            default: state_d = ST_FLOW;
        endcase
    end

    a_r9_one_cycle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> !hold);
    a_r8_no_load_no_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_is_load |-> !hold);
    a_r5_zero_dst_no_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_dst == '0) |-> !hold);
endmodule

// File: rtl/hazard_unit.sv
module hazard_unit
    import hzd_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] dec_src_a,
    input  logic [REG_AW-1:0] dec_src_b,
    input  logic [REG_AW-1:0] ex_src_a,
    input  logic [REG_AW-1:0] ex_src_b,
    input  logic [REG_AW-1:0] ex_dst,
    input  logic              ex_is_load,
    input  logic [REG_AW-1:0] mem_dst,
    input  logic              mem_wr_en,
    input  logic [REG_AW-1:0] wb_dst,
    input  logic              wb_wr_en,
    output logic [1:0]        fwd_sel_a,
    output logic [1:0]        fwd_sel_b,
    output logic              pc_wr_en,
    output logic              fd_wr_en,
    output logic              ex_bubble
);
    localparam int NUM_OPND = 2;

    logic [REG_AW-1:0] ex_src [NUM_OPND];
    opnd_sel_e         sel    [NUM_OPND];
    logic              hold;

    assign ex_src[0] = ex_src_a;
    assign ex_src[1] = ex_src_b;

    for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
        fwd_pick #(.RW(REG_AW)) u_pick (
            .src     (ex_src[g]),
            .mem_dst (mem_dst),
            .mem_wr  (mem_wr_en),
            .wb_dst  (wb_dst),
            .wb_wr   (wb_wr_en),
            .sel     (sel[g])
        );
    end

    load_use_fsm #(.RW(REG_AW)) u_lu (
        .clk        (clk),
        .rst_n      (rst_n),
        .dec_src_a  (dec_src_a),
        .dec_src_b  (dec_src_b),
        .ex_dst     (ex_dst),
        .ex_is_load (ex_is_load),
        .hold       (hold)
    );

    assign fwd_sel_a = sel[0];
    assign fwd_sel_b = sel[1];
    assign pc_wr_en  = !hold;
    assign fd_wr_en  = !hold;
    assign ex_bubble = hold;

    a_r2_mem_forward: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_en && mem_dst != '0 && mem_dst == ex_src_a) |-> fwd_sel_a == 2'b10);
    a_r3_wb_forward: assert property (@(posedge clk) disable iff (!rst_n)
        (!(mem_wr_en && mem_dst == ex_src_b) && wb_wr_en && wb_dst != '0 &&
         wb_dst == ex_src_b) |-> fwd_sel_b == 2'b01);
    a_r6_no_writers: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_wr_en && !wb_wr_en) |-> (fwd_sel_a == 2'b00 && fwd_sel_b == 2'b00));
    a_r7_freeze_together: assert property (@(posedge clk) disable iff (!rst_n)
        ex_bubble |-> (!pc_wr_en && !fd_wr_en));
endmodule

// File: tb/hazard_unit_tb.sv
module hazard_unit_tb_top;
    localparam int AW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] dec_src_a = '0, dec_src_b = '0, ex_src_a = '0, ex_src_b = '0;
    logic [AW-1:0] ex_dst = '0, mem_dst = '0, wb_dst = '0;
    logic ex_is_load = 1'b0, mem_wr_en = 1'b0, wb_wr_en = 1'b0;
    logic [1:0] fwd_sel_a, fwd_sel_b;
    logic pc_wr_en, fd_wr_en, ex_bubble;

    int checks = 0;
    int errors = 0;
    logic prev_stall = 1'b0;

    always #2 clk = ~clk;

    hazard_unit #(.REG_AW(AW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .dec_src_a(dec_src_a), .dec_src_b(dec_src_b),
        .ex_src_a(ex_src_a), .ex_src_b(ex_src_b),
        .ex_dst(ex_dst), .ex_is_load(ex_is_load),
        .mem_dst(mem_dst), .mem_wr_en(mem_wr_en),
        .wb_dst(wb_dst), .wb_wr_en(wb_wr_en),
        .fwd_sel_a(fwd_sel_a), .fwd_sel_b(fwd_sel_b),
        .pc_wr_en(pc_wr_en), .fd_wr_en(fd_wr_en), .ex_bubble(ex_bubble)
    );

    function automatic logic [1:0] exp_sel(logic [AW-1:0] s, logic [AW-1:0] md,
                                           logic mw, logic [AW-1:0] wd, logic ww);
        if (mw && md != 0 && md == s) return 2'b10;
        if (ww && wd != 0 && wd == s) return 2'b01;
        return 2'b00;
    endfunction

    function automatic logic exp_stall(logic held, logic ld, logic [AW-1:0] d,
                                       logic [AW-1:0] a, logic [AW-1:0] b);
        if (held) return 1'b0;
        return ld && d != 0 && (d == a || d == b);
    endfunction

    task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // drive one cycle at negedge, check combinational outputs 1 ns later
    task automatic step(string tag, logic [AW-1:0] da, logic [AW-1:0] db,
                        logic [AW-1:0] ea, logic [AW-1:0] eb, logic [AW-1:0] ed,
                        logic ld, logic [AW-1:0] md, logic mw,
                        logic [AW-1:0] wd, logic ww);
        logic st;
        @(negedge clk);
        dec_src_a = da; dec_src_b = db; ex_src_a = ea; ex_src_b = eb;
        ex_dst = ed; ex_is_load = ld; mem_dst = md; mem_wr_en = mw;
        wb_dst = wd; wb_wr_en = ww;
        #1;
        st = exp_stall(prev_stall, ld, ed, da, db);
        check({tag, " sel_a"}, {2'b00, fwd_sel_a}, {2'b00, exp_sel(ea, md, mw, wd, ww)});
        check({tag, " sel_b"}, {2'b00, fwd_sel_b}, {2'b00, exp_sel(eb, md, mw, wd, ww)});
        check({tag, " stall"}, {1'b0, pc_wr_en, fd_wr_en, ex_bubble}, {1'b0, !st, !st, st});
        prev_stall = st;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20241));
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset enables", {1'b0, pc_wr_en, fd_wr_en, ex_bubble}, 4'b0110);
        @(negedge clk);
        rst_n = 1'b1;
        step("R1 idle",           1, 2, 3, 4, 5, 0, 6, 1, 7, 1);
        step("R2 mem hit",        0, 0, 3, 9, 0, 0, 3, 1, 0, 0);
        step("R3 wb hit",         0, 0, 8, 4, 0, 0, 0, 0, 4, 1);
        step("R4 both hit",       0, 0, 6, 6, 0, 0, 6, 1, 6, 1);
        step("R10 split codes",   0, 0, 5, 7, 0, 0, 5, 1, 7, 1);
        step("R5 zero dst",       0, 0, 0, 0, 0, 1, 0, 1, 0, 1);
        step("R6 we low",         0, 0, 2, 3, 0, 0, 2, 0, 3, 0);
        step("R8 alu producer",   4, 4, 0, 0, 4, 0, 0, 0, 0, 0);
        step("R7 load src_b",     1, 9, 0, 0, 9, 1, 0, 0, 0, 0);
        step("R9 held cycle",     1, 9, 0, 0, 9, 1, 0, 0, 0, 0);
        step("R9 stall again",    1, 9, 0, 0, 9, 1, 0, 0, 0, 0);
        step("R9 release",        0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        step("R7 load src_a",     11, 2, 0, 0, 11, 1, 0, 0, 0, 0);
        for (int i = 0; i < 400; i++) begin
            step("R2 R3 R4 R5 R6 R7 R8 R9 R10 random",
                 AW'($urandom % 4), AW'($urandom % 4), AW'($urandom % 4),
                 AW'($urandom % 4), AW'($urandom % 4), 1'($urandom),
                 AW'($urandom % 4), 1'($urandom), AW'($urandom % 4), 1'($urandom));
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule